// File: doc/BRIEF.md
# Pixel-Bus Unpacking Multiplexer

This block turns a wide pixel-port word, delivered once per load, into a stream of narrow colour indices, one per dot-clock cycle. A word may carry 1, 2, 4 or 8 bit planes per pixel on a bus of 4 to 64 bits. The number of pixels taken from each word is the bus width divided by the bits per pixel. When the last pixel of a word is on the output, the block raises a load request, and the next word is captured at that same edge. An 8-bit VGA pixel path can be selected instead, which passes the VGA pixel through unchanged at one pixel per load.

Two 8-bit control registers, written through a small write port, select the mode. The first must hold 0x80 for any mode to be legal. The second packs a plane-count field, a bus-width field and a VGA-enable bit. A control write is held as pending and only takes effect at the next word boundary, so no word is ever split across two modes. An illegal setting silences the output until a legal value is written. The dot-to-load clock ratio outside the block has to be set to match the chosen mode. The block does not set it.

Top module: `pixmux_unpack`

## Requirements
- R1: After reset the first control register holds 0x80, the second holds 0x98 (VGA), and the pixel counter is zero. In the first cycle after reset is released, pix_idx is 0, pix_vld is 1 and load_req is 1. In the next cycle pix_idx shows vga_pix.
- R2: With control register 1 equal to 0x80, control register 2 bits [4:3] select the bits per pixel (0→1, 1→2, 2→4, 3→8). Bits [2:0] select the bus width (0→4, 1→8, 2→16, 3→32, 4→64 bits). Bits [6:5] have no effect.
- R3: Each word yields width/bpp pixels on consecutive cycles. load_req is high in exactly the cycle that shows the last pixel of the word.
- R4: The value on bus_word in a cycle with load_req high is captured at the end of that cycle. Its first pixel appears in the following cycle.
- R5: Pixels are taken from the least-significant end of the word first, each zero-extended to the 8-bit pix_idx. Word bits above the selected bus width have no effect.
- R6: Bit 7 of control register 2 set together with a legal pseudo-colour code selects that pseudo-colour mode (0x9B behaves as 0x1B).
- R7: Bit 7 set with bits [4:0] equal to 0x18 selects VGA mode. vga_pix is captured every cycle, appears on pix_idx one cycle later with pix_vld high, and load_req stays high.
- R8: Any of the following is illegal: width code 5 to 7, 8 planes with width code 0 and bit 7 clear, or control register 1 not equal to 0x80. An illegal mode drives pix_idx to 0 and pix_vld to 0, and keeps load_req high every cycle until a legal value takes effect.
- R9: A control write made in the middle of a word does not change the remaining pixels of that word or its load_req timing. The new mode applies from the next captured word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Control register write strobe |
| cfg_addr | input | 1 | Register select: 0 = control register 1, 1 = control register 2 |
| cfg_wdata | input | 8 | Control register write data |
| bus_word | input | BUS_W | Pixel-port word, captured in load_req cycles |
| vga_pix | input | 8 | VGA pixel for the pass-through mode |
| pix_idx | output | IDX_W | Current colour index |
| pix_vld | output | 1 | Index valid (low in an illegal mode) |
| load_req | output | 1 | Last pixel of the current word; the next word is taken at this edge |

## Verification
Every legal plane count is paired with several bus widths, including the extreme ratios of 64 pixels and 1 pixel per word. The words used have distinct nibbles and bytes, so a slice taken in the wrong order or at the wrong offset shows up as a wrong index. The VGA case drives vga_pix with the complement of the bus word, which tells pass-through apart from bus slicing. Codes that differ only in bit 7 or in bits [6:5] are compared against plain codes, and illegal codes from each of the three causes are followed by a legal code to show recovery. A write placed inside a word tells boundary-only switching apart from immediate switching.

// File: rtl/pixmux_pkg.sv
package pixmux_pkg;

  // Control register 1 value that enables any pixel mode
  localparam logic [7:0] CTL1_ENABLE = 8'h80;
  // Control register 2 reset value: VGA pass-through
  localparam logic [7:0] CTL2_RESET  = 8'h98;
  // Low five bits of control register 2 that, with bit 7, mean VGA
  localparam logic [4:0] VGA_LOW     = 5'b11000;

  typedef struct packed {
    logic       legal;      // mode produces pixels
    logic       vga;        // pass-through of the VGA pixel
    logic [1:0] plane_code; // log2 of bits per pixel
    logic [2:0] lg_ratio;   // log2 of pixels per word
  } mode_t;

  localparam mode_t MODE_VGA = '{legal: 1'b1, vga: 1'b1, plane_code: 2'd3, lg_ratio: 3'd0};

endpackage

// File: rtl/pixmux_cfg.sv
module pixmux_cfg
  import pixmux_pkg::*;
#(
  parameter int BUS_W = 64
) (
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       cfg_we,
  input  logic       cfg_addr,
  input  logic [7:0] cfg_wdata,
  output mode_t      pend_mode
);

  localparam int LG_BUS    = $clog2(BUS_W);
  localparam int MAX_WCODE = LG_BUS - 2;

  logic [7:0] ctl1_q, ctl1_d;
  logic [7:0] ctl2_q, ctl2_d;

  // next-state for the two control registers
  always_comb begin
    ctl1_d = ctl1_q;
    ctl2_d = ctl2_q;
    if (cfg_we) begin
      if (cfg_addr) ctl2_d = cfg_wdata;
      else          ctl1_d = cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl1_q <= CTL1_ENABLE;
      ctl2_q <= CTL2_RESET;
    end else if (cfg_we) begin
      ctl1_q <= ctl1_d;
      ctl2_q <= ctl2_d;
    end
  end

  // decode of the packed mode encoding
  logic [1:0] plane_f;
  logic [2:0] width_f;
  logic       vga_hit;
  logic       width_ok;
  logic       fits;

  always_comb begin
    plane_f  = ctl2_q[4:3];
    width_f  = ctl2_q[2:0];
    vga_hit  = ctl2_q[7] && (ctl2_q[4:0] == VGA_LOW);
    width_ok = int'(width_f) <= MAX_WCODE;
    fits     = (int'(width_f) + 2) >= int'(plane_f);
  end

  always_comb begin
    pend_mode = '0;
    if (ctl1_q == CTL1_ENABLE) begin
      if (vga_hit) begin
        pend_mode = MODE_VGA;
      end else if (width_ok && fits) begin
        pend_mode.legal      = 1'b1;
        pend_mode.plane_code = plane_f;
        pend_mode.lg_ratio   = 3'(int'(width_f) + 2 - int'(plane_f));
      end
    end
  end

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !cfg_we |=> ($stable(ctl1_q) && $stable(ctl2_q))) else $error("ctl changed without write"); // R2

endmodule

// File: rtl/pixmux_seq.sv
module pixmux_seq
  import pixmux_pkg::*;
#(
  parameter int BUS_W = 64
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  mode_t            pend_mode,
  input  logic [BUS_W-1:0] bus_word,
  input  logic [7:0]       vga_pix,
  output mode_t            act_mode,
  output logic [BUS_W-1:0] word_q,
  output logic [$clog2(BUS_W)-1:0] cnt_q,
  output logic             load_req
);

  localparam int CNT_W = $clog2(BUS_W);

  mode_t            act_q, act_d;
  logic [BUS_W-1:0] word_d;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] last_cnt;

  always_comb begin
    last_cnt = CNT_W'((32'd1 << act_q.lg_ratio) - 32'd1);
    load_req = (cnt_q == last_cnt);
  end

  // next state: step within a word, or take a new word and mode
  always_comb begin
    cnt_d  = cnt_q + CNT_W'(1);
    word_d = word_q;
    act_d  = act_q;
    if (load_req) begin
      cnt_d  = '0;
      act_d  = pend_mode;
      word_d = pend_mode.vga ? BUS_W'(vga_pix) : bus_word;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      act_q  <= MODE_VGA;
      word_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      word_q <= word_d;
    end
  end

  assign act_mode = act_q;

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_ni)
    load_req |=> (cnt_q == '0)) else $error("counter did not wrap"); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_ni)
    !load_req |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))) else $error("counter skipped"); // R3
  AST_MODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_ni)
    !load_req |=> $stable(act_q)) else $error("mode changed inside a word"); // R9
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !load_req |=> $stable(word_q)) else $error("word changed inside a word"); // R4

endmodule

// File: rtl/pixmux_pick.sv
module pixmux_pick
  import pixmux_pkg::*;
#(
  parameter int BUS_W = 64,
  parameter int IDX_W = 8
) (
  input  mode_t                    act_mode,
  input  logic [BUS_W-1:0]         word_q,
  input  logic [$clog2(BUS_W)-1:0] cnt_q,
  output logic [IDX_W-1:0]         pix_idx,
  output logic                     pix_vld
);

  localparam int N_PLANE_OPTS = 4;

  logic [IDX_W-1:0] cand [N_PLANE_OPTS];

  // one lane selector per bits-per-pixel option
  for (genvar p = 0; p < N_PLANE_OPTS; p++) begin : g_bpp
    localparam int BPP = 1 << p;
    localparam int N   = BUS_W / BPP;
    localparam int SW  = $clog2(N);

    logic [BPP-1:0] lane [N];
    logic [SW-1:0]  sel;

    for (genvar k = 0; k < N; k++) begin : g_lane
      assign lane[k] = word_q[k*BPP +: BPP];
    end

    assign sel     = cnt_q[SW-1:0];
    assign cand[p] = IDX_W'(lane[sel]);
  end

  always_comb begin
    pix_idx = '0;
    pix_vld = act_mode.legal;
    if (act_mode.legal) pix_idx = cand[act_mode.plane_code];
  end

endmodule

// File: rtl/pixmux_unpack.sv
module pixmux_unpack
  import pixmux_pkg::*;
#(
  parameter int BUS_W = 64,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_addr,
  input  logic [7:0]       cfg_wdata,
  input  logic [BUS_W-1:0] bus_word,
  input  logic [7:0]       vga_pix,
  output logic [IDX_W-1:0] pix_idx,
  output logic             pix_vld,
  output logic             load_req
);

  localparam int CNT_W = $clog2(BUS_W);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  mode_t            pend_mode;
  mode_t            act_mode;
  logic [BUS_W-1:0] word_q;
  logic [CNT_W-1:0] cnt_q;

  pixmux_cfg #(.BUS_W(BUS_W)) i_cfg (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .pend_mode (pend_mode)
  );

  pixmux_seq #(.BUS_W(BUS_W)) i_seq (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .pend_mode (pend_mode),
    .bus_word  (bus_word),
    .vga_pix   (vga_pix),
    .act_mode  (act_mode),
    .word_q    (word_q),
    .cnt_q     (cnt_q),
    .load_req  (load_req)
  );

  pixmux_pick #(.BUS_W(BUS_W), .IDX_W(IDX_W)) i_pick (
    .act_mode (act_mode),
    .word_q   (word_q),
    .cnt_q    (cnt_q),
    .pix_idx  (pix_idx),
    .pix_vld  (pix_vld)
  );

  AST_VGA_PASS: assert property (@(posedge clk) disable iff (!rst_ni)
    (load_req && pend_mode.vga) |=> (pix_vld && pix_idx == IDX_W'($past(vga_pix)))) else $error("vga pixel lost"); // R7
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_ni)
    (load_req && !pend_mode.legal) |=> (!pix_vld && pix_idx == '0)) else $error("illegal mode not quiet"); // R8
  AST_ILLEGAL_RELOAD: assert property (@(posedge clk) disable iff (!rst_ni)
    !pix_vld |-> load_req) else $error("illegal mode stopped requesting"); // R8
  AST_FIRST_LANE: assert property (@(posedge clk) disable iff (!rst_ni)
    (load_req && pend_mode.legal && !pend_mode.vga && pend_mode.plane_code == 2'd0)
      |=> (pix_idx == IDX_W'($past(bus_word[0])))) else $error("first pixel not from bit 0"); // R5

endmodule

// File: tb/test_pixmux_unpack.sv
module test_pixmux_unpack;

  localparam int BUS_W = 64;
  localparam int IDX_W = 8;
  localparam int NVEC  = 15;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_we;
  logic             cfg_addr;
  logic [7:0]       cfg_wdata;
  logic [BUS_W-1:0] bus_word;
  logic [7:0]       vga_pix;
  logic [IDX_W-1:0] pix_idx;
  logic             pix_vld;
  logic             load_req;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pixmux_unpack #(.BUS_W(BUS_W), .IDX_W(IDX_W)) i_pixmux_unpack (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .bus_word  (bus_word),
    .vga_pix   (vga_pix),
    .pix_idx   (pix_idx),
    .pix_vld   (pix_vld),
    .load_req  (load_req)
  );

  // {ctl1, ctl2, word}
  localparam logic [79:0] VECS [NVEC] = '{
    {8'h80, 8'h00, 64'h0123_4567_89AB_CDEF},  // R2 1 bpp, 4-bit bus
    {8'h80, 8'h04, 64'hF0E1_D2C3_B4A5_9687},  // R3 64 pixels per word
    {8'h80, 8'h0A, 64'hDEAD_BEEF_CAFE_F00D},  // R5 2 bpp, 16-bit bus
    {8'h80, 8'h13, 64'h1357_9BDF_2468_ACE0},  // R5 4 bpp, 32-bit bus
    {8'h80, 8'h1C, 64'h8877_6655_4433_2211},  // R5 8 bpp, 64-bit bus
    {8'h80, 8'h19, 64'hFFFF_FFFF_FFFF_FF3C},  // R3 1 pixel per word
    {8'h80, 8'h10, 64'h0000_0000_0000_00A9},  // R3 4 bpp on 4-bit bus
    {8'h80, 8'h9B, 64'h0F1E_2D3C_4B5A_6978},  // R6 bit 7 with pseudo code
    {8'h80, 8'h6B, 64'h5555_AAAA_3333_CCCC},  // R2 bits 6:5 ignored
    {8'h80, 8'h98, 64'h0000_0000_0000_0042},  // R7 VGA
    {8'h80, 8'h05, 64'h1111_2222_3333_4444},  // R8 reserved width code
    {8'h80, 8'h18, 64'h9999_8888_7777_6666},  // R8 8 planes on 4-bit bus
    {8'h00, 8'h0C, 64'hABCD_EF01_2345_6789},  // R8 ctl1 not enabled
    {8'h80, 8'h0C, 64'h2468_1357_9ACE_BDF0},  // R8 recovery, 2 bpp 64-bit
    {8'h80, 8'h0F, 64'h0000_0000_FFFF_0000}   // R8 width code 7
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [7:0] c1, input logic [7:0] c2,
                                output bit legal, output bit vga, output int bpp, output int ratio);
    int pc;
    int wc;
    pc    = int'(c2[4:3]);
    wc    = int'(c2[2:0]);
    bpp   = 1 << pc;
    vga   = (c1 == 8'h80) && c2[7] && (c2[4:0] == 5'h18);
    legal = vga || ((c1 == 8'h80) && (wc <= 4) && ((4 << wc) >= bpp));
    ratio = (legal && !vga) ? (4 << wc) / bpp : 1;
  endfunction

  task automatic cfg_write(input logic a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_vec(input logic [7:0] c1, input logic [7:0] c2, input logic [63:0] w);
    bit lg;
    bit vg;
    int bpp;
    int ratio;
    logic [7:0] exp;
    string tag;
    model(c1, c2, lg, vg, bpp, ratio);
    tag = !lg ? "R8" : vg ? "R7" : "R5";
    bus_word = w;
    vga_pix  = ~w[7:0];
    cfg_write(1'b0, c1);
    cfg_write(1'b1, c2);
    while (!load_req) @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < ratio; i++) begin
      if (!lg)      exp = 8'h00;
      else if (vg)  exp = ~w[7:0];
      else          exp = 8'((w >> (i * bpp)) & ((64'd1 << bpp) - 64'd1));
      check(pix_idx == exp, tag, 64'(pix_idx), 64'(exp));
      check(pix_vld == lg, tag, 64'(pix_vld), 64'(lg));
      check(load_req == (i == ratio - 1), "R3", 64'(load_req), 64'(i == ratio - 1));
      if (i < ratio - 1) @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = 1'b0; cfg_wdata = '0;
    bus_word = '0; vga_pix = 8'h5C;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // two synchroniser stages, then the reset state is visible
    @(negedge clk);
    @(negedge clk);
    check(pix_idx == 8'h00, "R1", 64'(pix_idx), 64'h0);
    check(pix_vld == 1'b1,  "R1", 64'(pix_vld), 64'h1);
    check(load_req == 1'b1, "R1", 64'(load_req), 64'h1);
    @(negedge clk);
    check(pix_idx == 8'h5C, "R1", 64'(pix_idx), 64'h5C);
    vga_pix = 8'hE7;
    @(negedge clk);
    check(pix_idx == 8'hE7, "R7", 64'(pix_idx), 64'hE7);

    for (int v = 0; v < NVEC; v++)
      run_vec(VECS[v][79:72], VECS[v][71:64], VECS[v][63:0]);

    // R9: write 8 bpp in the middle of a 1 bpp, 8-bit word
    bus_word = 64'h0000_0000_0000_00B2;
    cfg_write(1'b0, 8'h80);
    cfg_write(1'b1, 8'h01);
    while (!load_req) @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      if (i == 2) begin
        cfg_we = 1'b1; cfg_addr = 1'b1; cfg_wdata = 8'h19;
      end else begin
        cfg_we = 1'b0;
      end
      check(pix_idx == 8'((8'hB2 >> i) & 8'h1), "R9", 64'(pix_idx), 64'((8'hB2 >> i) & 8'h1));
      check(load_req == (i == 7), "R9", 64'(load_req), 64'(i == 7));
      if (i == 7) bus_word = 64'h0000_0000_0000_005A;
      @(negedge clk);
    end
    cfg_we = 1'b0;
    check(pix_idx == 8'h5A, "R9", 64'(pix_idx), 64'h5A);
    check(load_req == 1'b1, "R9", 64'(load_req), 64'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule